// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Contention Arbitration

This block is a clocked model of a true dual-port static memory. It has two symmetric ports, left and right. Each port can read or write any location in any cycle, including the location the other port is using. Each port has an address, an 18-bit data word made of two 9-bit byte lanes, a write strobe, a pair of chip enables, an output enable, a select for the semaphore space, and busy signalling. An access reaches the array only when the port is fully selected and its semaphore select is inactive.

When both ports select the same location in one cycle and at least one of them writes, contention logic picks a winner. A strap chooses between master and slave roles. In master mode the block makes the decision itself: the left port always wins, and the busy output of the right port rises during that cycle. In slave mode the block drives its busy outputs low and obeys busy inputs that come from a master. With this arrangement, several devices wired side by side as a wider word all block the same port.

Reads are registered, and every read in a cycle returns the contents from before that cycle's writes. A lane that is not enabled for a read returns zero and is flagged as not driven.

Top module: `dpram_arb`

## Requirements
- R1: A port is selected only when its `ce0_n` is 0, its `ce1` is 1 and its `sem_n` is 1. An unselected port neither writes the array nor drives read data.
- R2: A selected port with `we_n` = 0 writes the lanes it enables. `ub_n` = 0 enables bits 17:9 and `lb_n` = 0 enables bits 8:0. A disabled lane keeps its stored value.
- R3: A selected port with `we_n` = 1 and `oe_n` = 0 reads. One clock later, `rdata` holds the addressed word in every enabled lane and zero in the other lanes. `rdrv` bit 1 (upper) and bit 0 (lower) are 1 exactly for the lanes that were read. After reset both are zero.
- R4: The two ports work independently in the same cycle on any addresses. When no busy applies and both ports write the same lane of one location, the left value is stored.
- R5: In master mode (`ms_master` = 1), the right port loses when both ports are selected on the same address and at least one of them writes. `r_busy_o` is 1 in that same cycle, and `l_busy_o` is always 0.
- R6: A port that is held busy has its write suppressed in that cycle. The write of the winning port is stored.
- R7: A read in a contended cycle, on either port, returns the word as it was before that cycle's winning write.
- R8: When both ports only read the same location, no busy is raised and both ports get the stored data.
- R9: In slave mode (`ms_master` = 0), both busy outputs are 0. A port whose busy input is 1 has its write suppressed, and its reads are not affected.
- R10: A busy output follows the current cycle's inputs and returns to 0 in the first cycle without contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_master | input | 1 | Strap: 1 = master (generates busy), 0 = slave (obeys busy inputs) |
| l_addr | input | AW | Left port address |
| l_wdata | input | 18 | Left port write data |
| l_we_n | input | 1 | Left port write strobe, active low (1 = read) |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper lane select, active low |
| l_lb_n | input | 1 | Left lower lane select, active low |
| l_sem_n | input | 1 | Left semaphore-space select; array access only while 1 |
| l_busy_i | input | 1 | Left busy input, obeyed in slave mode |
| l_busy_o | output | 1 | Left busy output, always driven |
| l_rdata | output | 18 | Left registered read data |
| l_rdrv | output | 2 | Left per-lane read-data-valid (bit 1 upper, bit 0 lower) |
| r_addr | input | AW | Right port address |
| r_wdata | input | 18 | Right port write data |
| r_we_n | input | 1 | Right port write strobe, active low (1 = read) |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper lane select, active low |
| r_lb_n | input | 1 | Right lower lane select, active low |
| r_sem_n | input | 1 | Right semaphore-space select; array access only while 1 |
| r_busy_i | input | 1 | Right busy input, obeyed in slave mode |
| r_busy_o | output | 1 | Right busy output, always driven |
| r_rdata | output | 18 | Right registered read data |
| r_rdrv | output | 2 | Right per-lane read-data-valid (bit 1 upper, bit 0 lower) |

## Verification
A wrong arbitration decision shows up on a busy output in the cycle of the collision. It also shows up as a stored word that differs from the reference, but that error only becomes visible on `rdata` at the next read of that location, which may come many cycles later. Traffic is therefore confined to a few addresses that are read back often, so a lost or wrongly suppressed write reaches the ports within a few cycles. A wrong lane decode or a wrong read-ordering error appears on `rdata`/`rdrv` one clock after the faulty access.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Decoded request of one port, produced by the port decoder.
  typedef struct packed {
    logic       sel;   // chip fully enabled and array space addressed
    logic       wr;    // selected write
    logic       rd;    // selected read with output enabled
    logic [1:0] lane;  // [1] upper lane, [0] lower lane enabled
  } port_req_t;

  function automatic logic port_selected(input logic ce0_n, input logic ce1,
                                         input logic sem_n);
    return !ce0_n && ce1 && sem_n;
  endfunction

  // Same-location contention: both ports on the array, same word, any write.
  function automatic logic contend(input port_req_t a, input port_req_t b,
                                   input logic same_addr);
    return a.sel && b.sel && same_addr && (a.wr || b.wr);
  endfunction

endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec
  import dpram_pkg::*;
(
  input  logic      ce0_n,
  input  logic      ce1,
  input  logic      sem_n,
  input  logic      we_n,
  input  logic      oe_n,
  input  logic      ub_n,
  input  logic      lb_n,
  output port_req_t req
);

  always_comb begin
    req.sel  = port_selected(ce0_n, ce1, sem_n);
    req.wr   = req.sel && !we_n;
    req.rd   = req.sel && we_n && !oe_n;
    req.lane = {!ub_n, !lb_n};
  end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_master,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  input  port_req_t     req_l,
  input  port_req_t     req_r,
  input  logic          busy_l_i,
  input  logic          busy_r_i,
  output logic          busy_l_o,
  output logic          busy_r_o,
  output logic          block_l,
  output logic          block_r
);

  logic same_addr;
  logic collide;

  assign same_addr = (addr_l == addr_r);
  assign collide   = contend(req_l, req_r, same_addr);

  // Left wins ties; only the right port can be made busy by this device.
  assign busy_l_o = 1'b0;
  assign busy_r_o = ms_master && collide;

  assign block_l = ms_master ? 1'b0    : busy_l_i;
  assign block_r = ms_master ? collide : busy_r_i;

  AST_LEFT_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ms_master |-> !busy_l_o);  // R5

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_master && busy_r_o) |-> block_r);  // R6

  AST_SHARED_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_l.rd && req_r.rd) |-> (!busy_l_o && !busy_r_o));  // R8

  AST_SLAVE_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_master |-> (!busy_l_o && !busy_r_o));  // R9

endmodule

// File: rtl/dpram_core.sv
module dpram_core
  import dpram_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0][AW-1:0]       addr,
  input  logic [1:0][2*LW-1:0]     wdata,
  input  port_req_t [1:0]          req,
  input  logic [1:0]               block,
  output logic [1:0][2*LW-1:0]     rdata,
  output logic [1:0][1:0]          drv
);

  localparam int DEPTH = 1 << AW;
  localparam int WW    = 2 * LW;

  logic [WW-1:0]   mem [DEPTH];
  logic [1:0][1:0] lane_we;

  for (genvar p = 0; p < 2; p++) begin : g_port
    for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [LW-1:0] q_data;
      logic          q_drv;
      logic          lane_rd;

      assign lane_we[p][g] = req[p].wr && req[p].lane[g] && !block[p];
      assign lane_rd       = req[p].rd && req[p].lane[g];

      // Read-first: samples the array before this edge's writes land.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_data <= '0;
          q_drv  <= 1'b0;
        end else begin
          q_drv  <= lane_rd;
          q_data <= lane_rd ? mem[addr[p]][g*LW +: LW] : '0;
        end
      end

      assign rdata[p][g*LW +: LW] = q_data;
      assign drv[p][g]            = q_drv;
    end

    AST_NO_DRIVE_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !req[p].rd |=> (drv[p] == 2'b00));  // R3

    AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      req[p].wr |-> req[p].sel);  // R1
  end

  // Right port first, left last: left value stands if both land on one lane.
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      for (int g = 0; g < 2; g++) begin
        if (lane_we[p][g]) mem[addr[p]][g*LW +: LW] <= wdata[p][g*LW +: LW];
      end
    end
  end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpram_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_master,
  input  logic [AW-1:0]   l_addr,
  input  logic [2*LW-1:0] l_wdata,
  input  logic            l_we_n,
  input  logic            l_ce0_n,
  input  logic            l_ce1,
  input  logic            l_oe_n,
  input  logic            l_ub_n,
  input  logic            l_lb_n,
  input  logic            l_sem_n,
  input  logic            l_busy_i,
  output logic            l_busy_o,
  output logic [2*LW-1:0] l_rdata,
  output logic [1:0]      l_rdrv,
  input  logic [AW-1:0]   r_addr,
  input  logic [2*LW-1:0] r_wdata,
  input  logic            r_we_n,
  input  logic            r_ce0_n,
  input  logic            r_ce1,
  input  logic            r_oe_n,
  input  logic            r_ub_n,
  input  logic            r_lb_n,
  input  logic            r_sem_n,
  input  logic            r_busy_i,
  output logic            r_busy_o,
  output logic [2*LW-1:0] r_rdata,
  output logic [1:0]      r_rdrv
);

  port_req_t             req_l, req_r;
  logic                  block_l, block_r;
  logic [1:0][2*LW-1:0]  rdata_p;
  logic [1:0][1:0]       drv_p;

  dpram_port_dec u_dec_l (
    .ce0_n(l_ce0_n), .ce1(l_ce1), .sem_n(l_sem_n), .we_n(l_we_n),
    .oe_n(l_oe_n), .ub_n(l_ub_n), .lb_n(l_lb_n), .req(req_l)
  );

  dpram_port_dec u_dec_r (
    .ce0_n(r_ce0_n), .ce1(r_ce1), .sem_n(r_sem_n), .we_n(r_we_n),
    .oe_n(r_oe_n), .ub_n(r_ub_n), .lb_n(r_lb_n), .req(req_r)
  );

  dpram_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .ms_master(ms_master),
    .addr_l(l_addr), .addr_r(r_addr), .req_l(req_l), .req_r(req_r),
    .busy_l_i(l_busy_i), .busy_r_i(r_busy_i),
    .busy_l_o(l_busy_o), .busy_r_o(r_busy_o),
    .block_l(block_l), .block_r(block_r)
  );

  dpram_core #(.AW(AW), .LW(LW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .addr({r_addr, l_addr}),
    .wdata({r_wdata, l_wdata}),
    .req({req_r, req_l}),
    .block({block_r, block_l}),
    .rdata(rdata_p),
    .drv(drv_p)
  );

  assign l_rdata = rdata_p[0];
  assign r_rdata = rdata_p[1];
  assign l_rdrv  = drv_p[0];
  assign r_rdrv  = drv_p[1];

endmodule

// File: tb/test_dpram_arb.sv
module test_dpram_arb;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [17:0]   d;
    logic we_n, ce0_n, ce1, oe_n, ub_n, lb_n, sem_n, bi;
  } stim_t;

  typedef struct {
    int          port;
    logic [17:0] d;
    logic [1:0]  drv;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0, ms_master = 1;
  stim_t sl, sr;
  logic l_busy_o, r_busy_o;
  logic [17:0] l_rdata, r_rdata;
  logic [1:0]  l_rdrv, r_rdrv;

  logic [17:0] ref_mem [DEPTH];
  item_t q[$];
  int vectors = 0, miscompares = 0;
  logic ms_sel = 1;

  always #10 clk = ~clk;  // 50 MHz

  dpram_arb #(.AW(AW), .LW(9)) i_dpram_arb (
    .clk(clk), .rst_n(rst_n), .ms_master(ms_master),
    .l_addr(sl.a), .l_wdata(sl.d), .l_we_n(sl.we_n), .l_ce0_n(sl.ce0_n),
    .l_ce1(sl.ce1), .l_oe_n(sl.oe_n), .l_ub_n(sl.ub_n), .l_lb_n(sl.lb_n),
    .l_sem_n(sl.sem_n), .l_busy_i(sl.bi), .l_busy_o(l_busy_o),
    .l_rdata(l_rdata), .l_rdrv(l_rdrv),
    .r_addr(sr.a), .r_wdata(sr.d), .r_we_n(sr.we_n), .r_ce0_n(sr.ce0_n),
    .r_ce1(sr.ce1), .r_oe_n(sr.oe_n), .r_ub_n(sr.ub_n), .r_lb_n(sr.lb_n),
    .r_sem_n(sr.sem_n), .r_busy_i(sr.bi), .r_busy_o(r_busy_o),
    .r_rdata(r_rdata), .r_rdrv(r_rdrv)
  );

  function automatic stim_t idle();
    stim_t s = '0;
    s.we_n = 1; s.ce0_n = 1; s.ce1 = 0; s.oe_n = 1;
    s.ub_n = 1; s.lb_n = 1; s.sem_n = 1;
    return s;
  endfunction

  function automatic stim_t wr(input int a, input logic [17:0] d,
                               input logic ub_n = 0, input logic lb_n = 0);
    stim_t s = idle();
    s.a = AW'(a); s.d = d; s.we_n = 0; s.ce0_n = 0; s.ce1 = 1;
    s.ub_n = ub_n; s.lb_n = lb_n;
    return s;
  endfunction

  function automatic stim_t rd(input int a, input logic ub_n = 0,
                               input logic lb_n = 0);
    stim_t s = idle();
    s.a = AW'(a); s.ce0_n = 0; s.ce1 = 1; s.oe_n = 0;
    s.ub_n = ub_n; s.lb_n = lb_n;
    return s;
  endfunction

  function automatic logic [17:0] pat(input int a);
    logic [8:0] x = a[8:0];
    return {x ^ 9'h0A5, ~x ^ 9'(a >> 9)};
  endfunction

  task automatic check(input string tag, input logic [17:0] act,
                       input logic [17:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle on both ports, predicts busy and read results.
  task automatic step(input stim_t L, input stim_t R, input string tag);
    bit selL, selR, wrL, wrR, rdL, rdR, coll, blkL, blkR;
    item_t it;
    @(negedge clk);
    ms_master = ms_sel; sl = L; sr = R;
    selL = !L.ce0_n && L.ce1 && L.sem_n;
    selR = !R.ce0_n && R.ce1 && R.sem_n;
    wrL = selL && !L.we_n;  wrR = selR && !R.we_n;
    rdL = selL && L.we_n && !L.oe_n;  rdR = selR && R.we_n && !R.oe_n;
    coll = ms_sel && selL && selR && (L.a == R.a) && (wrL || wrR);
    blkL = ms_sel ? 1'b0 : L.bi;
    blkR = ms_sel ? coll : R.bi;
    it.tag = tag;
    it.port = 0; it.drv = {rdL && !L.ub_n, rdL && !L.lb_n};
    it.d = {it.drv[1] ? ref_mem[L.a][17:9] : 9'd0, it.drv[0] ? ref_mem[L.a][8:0] : 9'd0};
    q.push_back(it);
    it.port = 1; it.drv = {rdR && !R.ub_n, rdR && !R.lb_n};
    it.d = {it.drv[1] ? ref_mem[R.a][17:9] : 9'd0, it.drv[0] ? ref_mem[R.a][8:0] : 9'd0};
    q.push_back(it);
    #1;
    check(tag, {17'd0, l_busy_o}, 18'd0, "l_busy_o");
    check(tag, {17'd0, r_busy_o}, {17'd0, coll}, "r_busy_o");
    if (wrR && !blkR) begin
      if (!R.ub_n) ref_mem[R.a][17:9] = R.d[17:9];
      if (!R.lb_n) ref_mem[R.a][8:0]  = R.d[8:0];
    end
    if (wrL && !blkL) begin
      if (!L.ub_n) ref_mem[L.a][17:9] = L.d[17:9];
      if (!L.lb_n) ref_mem[L.a][8:0]  = L.d[8:0];
    end
  endtask

  // Monitor: after each edge, compares registered read outputs with predictions.
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        if (it.port == 0) begin
          check(it.tag, l_rdata, it.d, "l_rdata");
          check(it.tag, {16'd0, l_rdrv}, {16'd0, it.drv}, "l_rdrv");
        end else begin
          check(it.tag, r_rdata, it.d, "r_rdata");
          check(it.tag, {16'd0, r_rdrv}, {16'd0, it.drv}, "r_rdrv");
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    stim_t s;
    sl = idle(); sr = idle();
    repeat (3) @(posedge clk);
    #5;
    // R3: reset state of read outputs
    check("R3", l_rdata, 18'd0, "reset l_rdata");
    check("R3", {16'd0, r_rdrv}, 18'd0, "reset r_rdrv");
    rst_n = 1;

    // R4: both ports fill distinct halves concurrently
    for (int i = 0; i < DEPTH / 2; i++)
      step(wr(i, pat(i)), wr(i + DEPTH / 2, pat(i + DEPTH / 2)), "R4");
    step(rd(5), rd(600), "R4");
    step(rd(600), rd(5), "R4");

    // R2: lane masking on writes and reads
    step(wr(7, 18'h3FFFF, 0, 1), idle(), "R2");
    step(rd(7), wr(8, 18'h00000, 1, 0), "R2");
    step(rd(8), rd(7, 1, 0), "R2");
    step(rd(8, 0, 1), rd(7, 1, 1), "R3");

    // R1: partially selected or semaphore-space writes do not reach the array
    s = wr(9, 18'h12345); s.ce0_n = 1; step(s, idle(), "R1");
    s = wr(9, 18'h12345); s.ce1 = 0;   step(idle(), s, "R1");
    s = wr(9, 18'h12345); s.sem_n = 0; step(s, idle(), "R1");
    s = rd(9); s.sem_n = 0; step(s, rd(9), "R1");
    s = rd(9); s.oe_n = 1;  step(rd(9), s, "R3");

    // R5/R6: both write same location, left stored, right busy
    step(wr(20, 18'h0AAAA), wr(20, 18'h15555), "R5");
    step(rd(20), idle(), "R6");
    // R7: left reads while right writes, right blocked, left sees old data
    step(rd(21), wr(21, 18'h00FF0), "R7");
    step(rd(21), rd(21), "R6");
    // R7: right reads while left writes, right busy, old data returned
    step(wr(22, 18'h3C3C3), rd(22), "R7");
    // R10: busy drops in next uncontended cycle
    step(rd(22), rd(22), "R8");
    step(wr(23, 18'h11111), wr(24, 18'h22222), "R10");
    step(rd(23), rd(24), "R4");

    // R9: slave mode obeys busy inputs
    ms_sel = 0;
    s = wr(30, 18'h2F0F0); s.bi = 1; step(idle(), s, "R9");
    s = wr(31, 18'h1E1E1); s.bi = 1; step(s, rd(30), "R9");
    s = rd(31); s.bi = 1; step(s, wr(30, 18'h01234), "R9");
    step(wr(32, 18'h3AAAA), wr(32, 18'h05555), "R4");
    step(rd(30), rd(32), "R9");

    // Random contention traffic, master then slave
    for (int m = 1; m >= 0; m--) begin
      ms_sel = m[0];
      for (int i = 0; i < 3000; i++) begin
        stim_t L, R;
        L = idle(); R = idle();
        L.a = AW'($urandom_range(0, 7)); R.a = AW'($urandom_range(0, 7));
        L.d = 18'($urandom); R.d = 18'($urandom);
        L.we_n = 1'($urandom); R.we_n = 1'($urandom);
        L.ce0_n = ($urandom_range(0, 9) == 0); R.ce0_n = ($urandom_range(0, 9) == 0);
        L.ce1 = ($urandom_range(0, 9) != 0); R.ce1 = ($urandom_range(0, 9) != 0);
        L.sem_n = ($urandom_range(0, 9) != 0); R.sem_n = ($urandom_range(0, 9) != 0);
        L.oe_n = ($urandom_range(0, 5) == 0); R.oe_n = ($urandom_range(0, 5) == 0);
        L.ub_n = ($urandom_range(0, 3) == 0); R.ub_n = ($urandom_range(0, 3) == 0);
        L.lb_n = ($urandom_range(0, 3) == 0); R.lb_n = ($urandom_range(0, 3) == 0);
        L.bi = ($urandom_range(0, 3) == 0); R.bi = ($urandom_range(0, 3) == 0);
        step(L, R, m[0] ? "R5" : "R9");
      end
    end

    step(idle(), idle(), "R1");
    @(posedge clk); #3;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule